// File: doc/BRIEF.md
# Two-Level Page Table Walker

The block turns a logical address into a physical address by walking a page table that is itself split over pages. The logical address holds a page offset in its low bits and a page number above it. In two-level mode the page number is split into an outer index and an inner index. The walker works through these steps:

1. It reads the outer table entry.
2. That entry names the frame that holds the inner table.
3. It reads the inner entry, which names the data frame.
4. It joins that frame number to the offset to form the result.

Every table starts at the base of a frame, so a table pointer is stored as a bare frame number with zero offset bits. Memory is reached through a synchronous read port: data returns one cycle after the read strobe. This port addresses table entries, so entry index i of the table in frame f sits at `f * 2^OFF_W + i`. A build-time parameter selects single-level mode, where the whole page number indexes one table directly.

A client raises a request with a logical address while the unit is ready. Only one translation is in flight at a time. The answer is a one-cycle response carrying either a physical address or a fault flag. Each entry has a valid bit, and an invalid entry at any level ends the walk with a fault.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and right after it, `req_ready_o` is 1, `rsp_valid_o` is 0 and `mem_re_o` is 0.
- R2: A table entry is `{valid, frame}`, with the valid flag in bit FRAME_W and the frame in bits FRAME_W-1:0. A successful walk returns `rsp_paddr_o = {leaf frame, offset}`, where the offset is the low OFF_W bits of the logical address.
- R3: The logical address is `{p1, p2, offset}` with p1 in the top P1_W bits. The first read is issued in the cycle after acceptance, at entry address `ROOT_FRAME * 2^OFF_W + p1`.
- R4: When the outer entry is valid, the inner read is issued in the cycle right after the outer read, at entry address `outer_frame * 2^OFF_W + p2`.
- R5: For a two-level walk that reaches the inner entry, `rsp_valid_o` rises at the fourth rising edge counting the accepting edge as the first. It stays high for exactly one cycle, after which `req_ready_o` is 1 again.
- R6: An invalid outer entry gives a response with `rsp_fault_o`=1 and `rsp_paddr_o`=0, one cycle earlier than R5. No inner read is made.
- R7: An invalid inner entry gives a response with `rsp_fault_o`=1 and `rsp_paddr_o`=0, at the R5 timing.
- R8: `req_ready_o` is 0 from the cycle after acceptance until the response has been given. A request held during that time is ignored: exactly one response comes back, and it matches the accepted address.
- R9: In single-level mode the page number `{p1,p2}` indexes one table at `ROOT_FRAME * 2^OFF_W + page number`. Exactly one read is made, and the response comes at the third edge counting the accepting edge as the first. With 4-byte pages and page 0 mapped to frame 5, logical address 3 yields physical address 23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_laddr_i | input | P1_W+P2_W+OFF_W | Logical address to translate |
| req_ready_o | output | 1 | Unit idle; a request is taken at this edge |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_paddr_o | output | FRAME_W+OFF_W | Physical address, zero on fault |
| rsp_fault_o | output | 1 | Page fault at one of the levels |
| mem_re_o | output | 1 | Table entry read strobe |
| mem_addr_o | output | FRAME_W+OFF_W | Table entry address |
| mem_rdata_i | input | FRAME_W+1 | Entry read data, one cycle after the strobe |

## Verification
The bench builds two instances:

- **Two-level instance.** It uses a 4-bit offset, a 2/3 split of the page number, 4-bit frames and a root table in frame 1. This keeps the whole 256-entry table space small enough to model in full. It reaches every outer index, faults at both levels, the all-ones address, and a request held high while the walk is busy.
- **Single-level instance.** It uses 2-bit offsets, a 3-bit page number and 3-bit frames. This is exactly the 32-unit space with 4-unit pages, so the page-0-to-frame-5 example can be checked directly, along with a fault in the flat table.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OUTER,
    ST_MID,
    ST_LEAF,
    ST_RESP
  } walk_st_e;
endpackage

// File: rtl/pt_field_split.sv
module pt_field_split #(
  parameter int OFF_W = 11,
  parameter int P1_W = 6,
  parameter int P2_W = 9,
  parameter bit SINGLE_LEVEL = 1'b0,
  localparam int PN_W = P1_W + P2_W,
  localparam int LA_W = PN_W + OFF_W
) (
  input  logic [LA_W-1:0]  laddr_i,
  output logic [PN_W-1:0]  first_idx_o,
  output logic [P2_W-1:0]  second_idx_o,
  output logic [OFF_W-1:0] offset_o
);
  assign offset_o = laddr_i[OFF_W-1:0];

  generate
    if (SINGLE_LEVEL) begin : g_flat
      assign first_idx_o  = laddr_i[LA_W-1:OFF_W];
      assign second_idx_o = '0;
    end else begin : g_two
      assign first_idx_o  = {{P2_W{1'b0}}, laddr_i[LA_W-1:OFF_W+P2_W]};
      assign second_idx_o = laddr_i[OFF_W+P2_W-1:OFF_W];
    end
  endgenerate
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int OFF_W = 11,
  parameter int FRAME_W = 15,
  parameter int IDX_W = 15,
  localparam int PA_W = FRAME_W + OFF_W
) (
  input  logic [FRAME_W-1:0] base_frame_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [PA_W-1:0]    addr_o
);
  // tables are frame aligned: base offset bits are zero
  assign addr_o = {base_frame_i, {OFF_W{1'b0}}} + PA_W'(idx_i);
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
#(
  parameter int FRAME_W = 15,
  parameter bit SINGLE_LEVEL = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               ent_valid_i,
  input  logic [FRAME_W-1:0] ent_frame_i,
  output logic               req_ready_o,
  output logic               mem_re_o,
  output logic               sel_inner_o,
  output logic               rsp_valid_o,
  output logic               rsp_fault_o,
  output logic [FRAME_W-1:0] leaf_frame_o
);
  walk_st_e st_q, st_d;
  logic     leaf_cap;

  always_comb begin
    st_d        = st_q;
    req_ready_o = 1'b0;
    mem_re_o    = 1'b0;
    sel_inner_o = 1'b0;
    rsp_valid_o = 1'b0;
    leaf_cap    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        req_ready_o = 1'b1;
        if (req_valid_i) st_d = ST_OUTER;
      end
      ST_OUTER: begin
        mem_re_o = 1'b1;
        st_d     = ST_MID;
      end
      ST_MID: begin
        // first entry on rdata; chain straight into the inner read
        if (!SINGLE_LEVEL && ent_valid_i) begin
          mem_re_o    = 1'b1;
          sel_inner_o = 1'b1;
          st_d        = ST_LEAF;
        end else begin
          leaf_cap = 1'b1;
          st_d     = ST_RESP;
        end
      end
      ST_LEAF: begin
        leaf_cap = 1'b1;
        st_d     = ST_RESP;
      end
      ST_RESP: begin
        rsp_valid_o = 1'b1;
        st_d        = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      rsp_fault_o  <= 1'b0;
      leaf_frame_o <= '0;
    end else begin
      st_q <= st_d;
      if (leaf_cap) begin
        rsp_fault_o  <= !ent_valid_i;
        leaf_frame_o <= ent_valid_i ? ent_frame_i : '0;
      end
    end
  end

  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R5
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R8
  AST_FIRST_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (mem_re_o && !sel_inner_o)); // R3
  AST_INNER_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && sel_inner_o) |-> $past(mem_re_o && !sel_inner_o)); // R4

  generate
    if (SINGLE_LEVEL) begin : g_flat_chk
      AST_FLAT_ONE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_re_o |=> !mem_re_o); // R9
    end
  endgenerate
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int OFF_W = 11,
  parameter int P1_W = 6,
  parameter int P2_W = 9,
  parameter int FRAME_W = 15,
  parameter logic [FRAME_W-1:0] ROOT_FRAME = '0,
  parameter bit SINGLE_LEVEL = 1'b0,
  localparam int PN_W = P1_W + P2_W,
  localparam int LA_W = PN_W + OFF_W,
  localparam int PA_W = FRAME_W + OFF_W,
  localparam int ENT_W = FRAME_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [LA_W-1:0]  req_laddr_i,
  output logic             req_ready_o,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_fault_o,
  output logic             mem_re_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic [ENT_W-1:0] mem_rdata_i
);
  logic [LA_W-1:0]    laddr_q;
  logic [PN_W-1:0]    first_idx;
  logic [P2_W-1:0]    second_idx;
  logic [OFF_W-1:0]   offset;
  logic               sel_inner;
  logic [FRAME_W-1:0] leaf_frame;
  logic [FRAME_W-1:0] base_frame;
  logic [PN_W-1:0]    idx_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         laddr_q <= '0;
    else if (req_valid_i && req_ready_o) laddr_q <= req_laddr_i;
  end

  pt_field_split #(
    .OFF_W(OFF_W), .P1_W(P1_W), .P2_W(P2_W), .SINGLE_LEVEL(SINGLE_LEVEL)
  ) u_split (
    .laddr_i     (laddr_q),
    .first_idx_o (first_idx),
    .second_idx_o(second_idx),
    .offset_o    (offset)
  );

  assign base_frame = sel_inner ? mem_rdata_i[FRAME_W-1:0] : ROOT_FRAME;
  assign idx_sel    = sel_inner ? {{P1_W{1'b0}}, second_idx} : first_idx;

  pt_entry_addr #(
    .OFF_W(OFF_W), .FRAME_W(FRAME_W), .IDX_W(PN_W)
  ) u_addr (
    .base_frame_i(base_frame),
    .idx_i       (idx_sel),
    .addr_o      (mem_addr_o)
  );

  pt_walk_ctrl #(
    .FRAME_W(FRAME_W), .SINGLE_LEVEL(SINGLE_LEVEL)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .ent_valid_i (mem_rdata_i[FRAME_W]),
    .ent_frame_i (mem_rdata_i[FRAME_W-1:0]),
    .req_ready_o (req_ready_o),
    .mem_re_o    (mem_re_o),
    .sel_inner_o (sel_inner),
    .rsp_valid_o (rsp_valid_o),
    .rsp_fault_o (rsp_fault_o),
    .leaf_frame_o(leaf_frame)
  );

  assign rsp_paddr_o = rsp_fault_o ? '0 : {leaf_frame, offset};

  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> $stable(laddr_q)); // R8
endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // two-level instance: OFF 4, P1 2, P2 3, FRAME 4, root frame 1
  logic       req_valid_a = 1'b0;
  logic [8:0] laddr_a = '0;
  logic       ready_a, rsp_valid_a, fault_a, re_a;
  logic [7:0] paddr_a, addr_a;
  logic [4:0] rdata_a = '0;
  logic [4:0] mem_a [256];

  // single-level instance: OFF 2, PN 3, FRAME 3, root frame 1
  logic       req_valid_b = 1'b0;
  logic [4:0] laddr_b = '0;
  logic       ready_b, rsp_valid_b, fault_b, re_b;
  logic [4:0] paddr_b, addr_b;
  logic [3:0] rdata_b = '0;
  logic [3:0] mem_b [32];

  logic [7:0] exp_rd_a [$];
  logic [8:0] exp_rsp_a [$];
  logic [4:0] exp_rd_b [$];
  logic [5:0] exp_rsp_b [$];

  pt_walker #(.OFF_W(4), .P1_W(2), .P2_W(3), .FRAME_W(4), .ROOT_FRAME(4'd1),
              .SINGLE_LEVEL(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid_a), .req_laddr_i(laddr_a),
    .req_ready_o(ready_a), .rsp_valid_o(rsp_valid_a), .rsp_paddr_o(paddr_a),
    .rsp_fault_o(fault_a), .mem_re_o(re_a), .mem_addr_o(addr_a), .mem_rdata_i(rdata_a));

  pt_walker #(.OFF_W(2), .P1_W(1), .P2_W(2), .FRAME_W(3), .ROOT_FRAME(3'd1),
              .SINGLE_LEVEL(1'b1)) uut_flat (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid_b), .req_laddr_i(laddr_b),
    .req_ready_o(ready_b), .rsp_valid_o(rsp_valid_b), .rsp_paddr_o(paddr_b),
    .rsp_fault_o(fault_b), .mem_re_o(re_b), .mem_addr_o(addr_b), .mem_rdata_i(rdata_b));

  always @(posedge clk) begin
    if (re_a) rdata_a <= mem_a[addr_a];
    if (re_b) rdata_b <= mem_b[addr_b];
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  // monitors
  always @(negedge clk) begin : mon
    logic [8:0] e;
    if (rst_n) begin
      if (re_a) begin
        if (exp_rd_a.size() == 0) chk(1'b0, "R3 R4 unexpected read", int'(addr_a), -1);
        else begin
          e = 9'(exp_rd_a.pop_front());
          chk(addr_a == e[7:0], "R3 R4 read address", int'(addr_a), int'(e[7:0]));
        end
      end
      if (rsp_valid_a) begin
        if (exp_rsp_a.size() == 0) chk(1'b0, "R8 unexpected response", int'(paddr_a), -1);
        else begin
          e = exp_rsp_a.pop_front();
          chk({fault_a, paddr_a} == e, "R2 R6 R7 response {fault,paddr}",
              int'({fault_a, paddr_a}), int'(e));
        end
      end
      if (re_b) begin
        if (exp_rd_b.size() == 0) chk(1'b0, "R9 unexpected read", int'(addr_b), -1);
        else begin
          e = 9'(exp_rd_b.pop_front());
          chk(addr_b == e[4:0], "R9 read address", int'(addr_b), int'(e[4:0]));
        end
      end
      if (rsp_valid_b) begin
        if (exp_rsp_b.size() == 0) chk(1'b0, "R9 unexpected response", int'(paddr_b), -1);
        else begin
          e = 9'(exp_rsp_b.pop_front());
          chk({fault_b, paddr_b} == e[5:0], "R9 response {fault,paddr}",
              int'({fault_b, paddr_b}), int'(e[5:0]));
        end
      end
    end
  end

  task automatic run_a(input logic [8:0] la, input int lat, input bit hold, input string tag);
    logic [7:0] oa, ia;
    logic [4:0] oe, ie;
    int n;
    oa = {4'd1, 2'b00, la[8:7]};
    oe = mem_a[oa];
    exp_rd_a.push_back(oa);
    if (!oe[4]) exp_rsp_a.push_back(9'h100);
    else begin
      ia = {oe[3:0], 1'b0, la[6:4]};
      exp_rd_a.push_back(ia);
      ie = mem_a[ia];
      exp_rsp_a.push_back(ie[4] ? {1'b0, ie[3:0], la[3:0]} : 9'h100);
    end
    @(negedge clk);
    req_valid_a = 1'b1;
    laddr_a = la;
    @(posedge clk);
    @(negedge clk);
    if (hold) laddr_a = la ^ 9'h1ff;
    else req_valid_a = 1'b0;
    n = 1;
    while (!rsp_valid_a && n < 20) begin
      chk(!ready_a, {tag, " R8 ready low while busy"}, int'(ready_a), 0);
      @(negedge clk);
      n++;
      if (n == 2) req_valid_a = 1'b0;
    end
    chk(n == lat, {tag, " R5 response latency"}, n, lat);
    @(negedge clk);
    chk(!rsp_valid_a && ready_a, {tag, " R5 single pulse then ready"},
        int'({rsp_valid_a, ready_a}), 1);
  endtask

  task automatic run_b(input logic [4:0] la, input string tag);
    logic [4:0] ad;
    logic [3:0] en;
    int n;
    ad = 5'd4 + 5'(la[4:2]);
    en = mem_b[ad];
    exp_rd_b.push_back(ad);
    exp_rsp_b.push_back(en[3] ? {1'b0, en[2:0], la[1:0]} : 6'h20);
    @(negedge clk);
    req_valid_b = 1'b1;
    laddr_b = la;
    @(posedge clk);
    @(negedge clk);
    req_valid_b = 1'b0;
    n = 1;
    while (!rsp_valid_b && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(n == 3, {tag, " R9 flat latency"}, n, 3);
    @(negedge clk);
    chk(!rsp_valid_b && ready_b, {tag, " R9 pulse then ready"},
        int'({rsp_valid_b, ready_b}), 1);
  endtask

  initial begin : wdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 256; i++) mem_a[i] = '0;
    for (int i = 0; i < 32; i++) mem_b[i] = '0;
    // outer table in frame 1: p1=2 invalid
    mem_a[16] = {1'b1, 4'd2};
    mem_a[17] = {1'b1, 4'd3};
    mem_a[19] = {1'b1, 4'd4};
    for (int f = 2; f <= 4; f++)
      for (int p = 0; p < 8; p++)
        mem_a[f*16+p] = (p == 7) ? 5'd0 : {1'b1, 4'((f*3 + p*5 + 1) % 16)};
    // flat table at frame 1: entry addresses 4..11, page 4 invalid
    for (int p = 0; p < 8; p++) mem_b[4+p] = {1'b1, 3'(p)};
    mem_b[4] = {1'b1, 3'd5};
    mem_b[6] = {1'b1, 3'd1};
    mem_b[8] = 4'd0;

    repeat (3) @(negedge clk);
    chk(ready_a && !rsp_valid_a && !re_a, "R1 in reset (two-level)",
        int'({ready_a, rsp_valid_a, re_a}), 4);
    chk(ready_b && !rsp_valid_b && !re_b, "R1 in reset (flat)",
        int'({ready_b, rsp_valid_b, re_b}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready_a && !rsp_valid_a && !re_a, "R1 after reset",
        int'({ready_a, rsp_valid_a, re_a}), 4);

    run_b(5'd3, "flat page0->frame5");          // R9: expect 23
    run_b({3'd4, 2'd1}, "flat fault");
    run_b({3'd7, 2'd2}, "flat page7");
    run_b({3'd2, 2'd0}, "flat page2");

    run_a({2'd0, 3'd0, 4'd5}, 4, 1'b0, "R2 p1=0 p2=0");
    run_a({2'd1, 3'd3, 4'd15}, 4, 1'b0, "R2 p1=1 p2=3");
    run_a({2'd3, 3'd6, 4'd0}, 4, 1'b0, "R2 p1=3 p2=6");
    run_a({2'd2, 3'd1, 4'd9}, 3, 1'b0, "R6 outer invalid");
    run_a({2'd0, 3'd7, 4'd3}, 4, 1'b0, "R7 inner invalid");
    run_a(9'h1ff, 4, 1'b0, "R7 all ones");
    run_a({2'd3, 3'd2, 4'd10}, 4, 1'b1, "R8 held request");
    for (int p = 0; p < 7; p++)
      run_a({2'd1, 3'(p), 4'(p*2+1)}, 4, 1'b0, "R4 sweep");

    repeat (8) @(negedge clk);
    chk(exp_rsp_a.size() == 0 && exp_rd_a.size() == 0, "R8 all expected items seen",
        exp_rsp_a.size() + exp_rd_a.size(), 0);
    chk(exp_rsp_b.size() == 0 && exp_rd_b.size() == 0, "R9 all expected items seen",
        exp_rsp_b.size() + exp_rd_b.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule